// File: doc/BRIEF.md
# Clock Prescaler and Timebase Controller

This block sits beside the CPU of a small microcontroller and derives the CPU clock from the oscillator-derived input clock. The CPU clock is delivered as a clock-enable, `cpu_ce`. In normal mode it is high on every input cycle. In slow mode it pulses once every 2, 4, 8 or 16 cycles. A second counter, the timebase, wraps after a programmable number of input cycles. On each wrap it sets a flag that can raise an interrupt. A clock-out pin driver follows the CPU clock when software enables it.

Software reaches the block through one 8-bit control/status register, using separate read and write strobes. A ratio or timebase change never cuts the interval that is already running. A divider change waits for the next `cpu_ce` pulse. A timebase change waits for the end of the current period, so the timebase keeps its phase and can serve as a real-time clock.

A halt request enters one of two modes, chosen by the interrupt enable:
- **Active-halt**: the timebase keeps counting so that its interrupt can end the mode.
- **Full halt**: the timebase is frozen.

In both modes the register ignores bus writes and read-clears.

Top module: `clkctl_tbase`

## Requirements
- R1: After reset the register reads 00h, and `tb_irq`, `clk_out` and `ahalt_mode` are 0.
- R2: Register bit 7 is the clock-out enable, bits 6:5 the slow ratio, bit 4 the slow-mode enable, bits 3:2 the timebase select and bit 1 the interrupt enable; these bits read back as written. Bit 0 is the timebase flag and a write to bit 0 has no effect on it.
- R3: With bit 4 = 0, `cpu_ce` is high every cycle. With bit 4 = 1, `cpu_ce` pulses once every 2, 4, 8 or 16 cycles for slow ratio 0, 1, 2 or 3.
- R4: A change of bits 6:4 takes effect at the next `cpu_ce` pulse. The interval in progress completes at its old length.
- R5: The timebase period is TB_PER0, TB_PER1, TB_PER2 or TB_PER3 input cycles (defaults 16000, 32000, 80000, 200000) for select codes 0 to 3.
- R6: A change of the timebase select takes effect only when the running period ends. The running count is not restarted.
- R7: Each timebase wrap sets the flag (bit 0) on the following edge. `tb_irq` is high exactly when the flag and the interrupt enable are both 1.
- R8: A read strobe clears the flag on the next edge. If a wrap occurs in the same cycle, the flag stays set.
- R9: `halt_req` with interrupt enable = 1 is active-halt: `ahalt_mode` = 1, the timebase keeps counting and can set the flag, and bus writes and read-clears are ignored.
- R10: `halt_req` with interrupt enable = 0 is full halt. The timebase count and the register are frozen, and counting resumes from the held value when `halt_req` falls.
- R11: `clk_out` equals `cpu_ce` when bit 7 = 1 and the block is not in active-halt. Otherwise `clk_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-derived input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the flag) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register contents |
| halt_req | input | 1 | Halt request from the power manager |
| cpu_ce | output | 1 | CPU clock enable |
| clk_out | output | 1 | Clock-out pin driver |
| tb_irq | output | 1 | Timebase interrupt request |
| ahalt_mode | output | 1 | High while the halt request is active-halt |

## Verification
The hardest situations to reach from the ports are tied to exact cycles. One is a read strobe that lands in the same cycle as a timebase wrap. Another is a wrap that happens while active-halt has locked the bus. A third is a halt window that has to shift the next wrap by exactly its own length. The bench timestamps each observed flag rise with a free-running cycle count. It then places the read strobe, the halt window and the timebase rewrite at computed offsets from that rise. Divider behaviour is measured the same way, as intervals between `cpu_ce` pulses around a ratio rewrite.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int unsigned MAX_DIV_LOG2 = 4;
  localparam int unsigned RATIO_W = 3;

  typedef struct packed {
    logic       out_en;    // bit 7
    logic [1:0] slow_div;  // bits 6:5
    logic       slow_on;   // bit 4
    logic [1:0] tb_sel;    // bits 3:2
    logic       irq_en;    // bit 1
  } ctrl_t;

  // log2 of the CPU clock division ratio
  function automatic logic [RATIO_W-1:0] div_log2(input logic slow_on,
                                                  input logic [1:0] slow_div);
    return slow_on ? ({1'b0, slow_div} + 3'd1) : 3'd0;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/clkctl_prescaler.sv
module clkctl_prescaler #(
  parameter int unsigned CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ratio_log2,
  output logic       ce
);

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] reload(input logic [2:0] l2);
    return CNT_W'((32'd1 << l2) - 32'd1);
  endfunction

  // ratio is sampled only at a boundary, so a period is never cut short
  assign ce = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt <= '0;
    else if (ce) cnt <= reload(ratio_log2);
    else         cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/clkctl_timebase.sv
module clkctl_timebase #(
  parameter int unsigned PER0 = 16000,
  parameter int unsigned PER1 = 32000,
  parameter int unsigned PER2 = 80000,
  parameter int unsigned PER3 = 200000,
  parameter int unsigned CW   = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       wrap
);

  logic [1:0]    cur_sel;
  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] last_of(input logic [1:0] code);
    case (code)
      2'd0:    return CW'(PER0 - 1);
      2'd1:    return CW'(PER1 - 1);
      2'd2:    return CW'(PER2 - 1);
      default: return CW'(PER3 - 1);
    endcase
  endfunction

  assign wrap = run && (cnt == last_of(cur_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      cur_sel <= 2'd0;
    end else if (run) begin
      if (wrap) begin
        cnt     <= '0;
        cur_sel <= sel;   // new select adopted only at period end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       rd,
  input  logic [6:0] wdata,
  input  logic       lock,
  input  logic       set_flag,
  output ctrl_t      ctrl,
  output logic       flag
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      flag <= 1'b0;
    end else begin
      if (wr && !lock) ctrl <= ctrl_t'(wdata);
      if (set_flag)         flag <= 1'b1;
      else if (rd && !lock) flag <= 1'b0;
    end
  end

endmodule

// File: rtl/clkctl_tbase.sv
module clkctl_tbase
  import clkctl_pkg::*;
#(
  parameter int unsigned TB_PER0 = 16000,
  parameter int unsigned TB_PER1 = 32000,
  parameter int unsigned TB_PER2 = 80000,
  parameter int unsigned TB_PER3 = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       halt_req,
  output logic       cpu_ce,
  output logic       clk_out,
  output logic       tb_irq,
  output logic       ahalt_mode
);

  localparam int unsigned TB_MAX = max4(TB_PER0, TB_PER1, TB_PER2, TB_PER3);
  localparam int unsigned TB_CW  = $clog2(TB_MAX);
  localparam int unsigned PS_W   = MAX_DIV_LOG2;

  ctrl_t ctrl;
  logic  flag;
  logic  full_halt;
  logic  tb_wrap;
  logic  wdata_bit0_unused;

  assign wdata_bit0_unused = reg_wdata[0];
  assign ahalt_mode = halt_req & ctrl.irq_en;
  assign full_halt  = halt_req & ~ctrl.irq_en;

  clkctl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .wdata    (reg_wdata[7:1]),
    .lock     (halt_req),
    .set_flag (tb_wrap),
    .ctrl     (ctrl),
    .flag     (flag)
  );

  clkctl_prescaler #(.CNT_W(PS_W)) u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .ratio_log2 (div_log2(ctrl.slow_on, ctrl.slow_div)),
    .ce         (cpu_ce)
  );

  clkctl_timebase #(
    .PER0 (TB_PER0), .PER1 (TB_PER1), .PER2 (TB_PER2), .PER3 (TB_PER3), .CW (TB_CW)
  ) u_tbase (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (~full_halt),
    .sel   (ctrl.tb_sel),
    .wrap  (tb_wrap)
  );

  assign reg_rdata = {ctrl, flag};
  assign tb_irq    = flag & ctrl.irq_en;
  assign clk_out   = cpu_ce & ctrl.out_en & ~ahalt_mode;

endmodule

// File: rtl/clkctl_tbase_chk.sv
module clkctl_tbase_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_rd,
  input logic [7:0] reg_rdata,
  input logic       halt_req,
  input logic       cpu_ce,
  input logic       clk_out,
  input logic       tb_irq,
  input logic       ahalt_mode,
  input logic       tb_wrap
);

  logic [4:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n || cpu_ce) gap <= 5'd0;
    else if (gap != 5'd31) gap <= gap + 5'd1;
  end

  assert_ce_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= 5'd15);

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tb_wrap |=> reg_rdata[0]);

  assert_irq_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tb_irq |-> (reg_rdata[0] && reg_rdata[1]));

  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !halt_req && !tb_wrap) |=> !reg_rdata[0]);

  // covers both halt kinds (R9 and R10)
  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> $stable(reg_rdata[7:1]));

  assert_no_wrap_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !reg_rdata[1]) |-> !tb_wrap);

  assert_clkout_ahalt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ahalt_mode |-> !clk_out);

  assert_clkout_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out |-> (cpu_ce && reg_rdata[7]));

endmodule

bind clkctl_tbase clkctl_tbase_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_rd     (reg_rd),
  .reg_rdata  (reg_rdata),
  .halt_req   (halt_req),
  .cpu_ce     (cpu_ce),
  .clk_out    (clk_out),
  .tb_irq     (tb_irq),
  .ahalt_mode (ahalt_mode),
  .tb_wrap    (tb_wrap)
);

// File: tb/clkctl_tbase_test.sv
module clkctl_tbase_test;

  localparam int CLK_PERIOD = 10;
  localparam int P0 = 20, P1 = 30, P2 = 50, P3 = 80;

  logic       clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0, halt = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata;
  logic       ce, co, irq, ah;
  int         cyc = 0, n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkctl_tbase #(.TB_PER0(P0), .TB_PER1(P1), .TB_PER2(P2), .TB_PER3(P3)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_rd(rd), .reg_wdata(wd),
    .reg_rdata(rdata), .halt_req(halt), .cpu_ce(ce), .clk_out(co),
    .tb_irq(irq), .ahalt_mode(ah)
  );

  function automatic int per_of(input int code);
    case (code)
      0: return P0;
      1: return P1;
      2: return P2;
      default: return P3;
    endcase
  endfunction

  // fields: out_en[7], slow ratio[6:5], slow_on[4], tb select[3:2], irq_en[1]
  function automatic logic [7:0] mk(input int oe, input int dv, input int sl,
                                    input int tb, input int ie);
    return {oe[0], dv[1:0], sl[0], tb[1:0], ie[0], 1'b0};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_csr(input logic [7:0] v);
    wd = v; wr = 1'b1; step(); wr = 1'b0;
  endtask

  task automatic rd_csr();
    rd = 1'b1; step(); rd = 1'b0;
  endtask

  task automatic wait_flag(output int t);
    step();
    while (!rdata[0]) step();
    t = cyc;
  endtask

  task automatic wait_ce(output int t);
    step();
    while (!ce) step();
    t = cyc;
  endtask

  task automatic t_reset();
    check(rdata == 8'h00, "R1 register", rdata, 0);
    check(irq == 1'b0, "R1 tb_irq", irq, 0);
    check(co == 1'b0, "R1 clk_out", co, 0);
    check(ah == 1'b0, "R1 ahalt_mode", ah, 0);
  endtask

  task automatic t_regs();
    rd_csr();
    wr_csr(8'hAB);
    check(rdata[7:1] == 7'h55, "R2 fields readback", rdata[7:1], 7'h55);
    check(rdata[0] == 1'b0, "R2 bit0 write ignored", rdata[0], 0);
    wr_csr(8'h00);
  endtask

  task automatic t_prescale();
    int bad = 0;
    int a, b;
    for (int i = 0; i < 6; i++) begin
      step();
      if (!ce) bad++;
    end
    check(bad == 0, "R3 normal mode every cycle", bad, 0);
    for (int cp = 0; cp < 4; cp++) begin
      wr_csr(mk(0, cp, 1, 0, 0));
      wait_ce(a);
      wait_ce(b);
      check(b - a == (2 << cp), "R3 slow interval", b - a, 2 << cp);
    end
  endtask

  task automatic t_glitch();
    int a, b, c, d;
    wr_csr(mk(0, 3, 1, 0, 0));
    wait_ce(a);
    wait_ce(b);
    wr_csr(mk(0, 0, 1, 0, 0));
    wait_ce(c);
    wait_ce(d);
    check(c - b == 16, "R4 running interval kept", c - b, 16);
    check(d - c == 2, "R4 new ratio after boundary", d - c, 2);
    wr_csr(8'h00);
  endtask

  task automatic t_period();
    int a, b;
    for (int code = 0; code < 4; code++) begin
      wr_csr(mk(0, 0, 0, code, 0));
      rd_csr();
      wait_flag(a);
      rd_csr();
      wait_flag(b);
      rd_csr();
      check(b - a == per_of(code), "R5 timebase period", b - a, per_of(code));
    end
  endtask

  task automatic t_defer();
    int a, b, c, d;
    wr_csr(mk(0, 0, 0, 0, 0));
    rd_csr();
    wait_flag(a);
    rd_csr();
    wait_flag(b);
    rd_csr();
    repeat (4) step();
    wr_csr(mk(0, 0, 0, 3, 0));
    wait_flag(c);
    rd_csr();
    wait_flag(d);
    rd_csr();
    check(c - b == P0, "R6 running period not restarted", c - b, P0);
    check(d - c == P3, "R6 new select after period end", d - c, P3);
  endtask

  task automatic t_flag_irq();
    int a;
    wr_csr(mk(0, 0, 0, 0, 1));
    rd_csr();
    wait_flag(a);
    check(irq == 1'b1, "R7 irq with flag and enable", irq, 1);
    rd_csr();
    check(rdata[0] == 1'b0, "R8 read clears flag", rdata[0], 0);
    check(irq == 1'b0, "R7 irq drops with flag", irq, 0);
    while (cyc < a + P0 - 1) step();
    rd = 1'b1; step(); rd = 1'b0;
    check(rdata[0] == 1'b1, "R8 wrap wins over read", rdata[0], 1);
    wr_csr(mk(0, 0, 0, 0, 0));
    check(irq == 1'b0, "R7 irq masked by enable", irq, 0);
    rd_csr();
  endtask

  task automatic t_ahalt();
    int a, bad;
    logic [7:0] cfg;
    cfg = mk(1, 0, 1, 0, 1);
    wr_csr(cfg);
    rd_csr();
    wait_flag(a);
    rd_csr();
    halt = 1'b1;
    step();
    check(ah == 1'b1, "R9 active-halt selected", ah, 1);
    wr_csr(8'h00);
    bad = 0;
    while (cyc < a + P0) begin
      step();
      if (co) bad++;
    end
    check(bad == 0, "R11 clk_out low in active-halt", bad, 0);
    check(rdata[0] == 1'b1, "R9 timebase runs, flag set", rdata[0], 1);
    check(irq == 1'b1, "R9 irq raised in active-halt", irq, 1);
    rd_csr();
    check(rdata[0] == 1'b1, "R9 read-clear ignored", rdata[0], 1);
    halt = 1'b0;
    step();
    check(rdata[7:1] == cfg[7:1], "R9 write ignored", rdata[7:1], cfg[7:1]);
    check(ah == 1'b0, "R9 mode left", ah, 0);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      step();
      if (co != ce) bad++;
    end
    check(bad == 0, "R11 clk_out follows cpu_ce", bad, 0);
    wr_csr(mk(0, 0, 1, 0, 1));
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      step();
      if (co) bad++;
    end
    check(bad == 0, "R11 clk_out off when disabled", bad, 0);
    rd_csr();
  endtask

  task automatic t_fhalt();
    int a, b, bad;
    wr_csr(mk(0, 0, 0, 0, 0));
    rd_csr();
    wait_flag(a);
    rd_csr();
    repeat (5) step();
    halt = 1'b1;
    wr_csr(8'hFF);
    bad = 0;
    for (int i = 0; i < 29; i++) begin
      step();
      if (rdata[0] || ah) bad++;
    end
    halt = 1'b0;
    check(bad == 0, "R10 no flag, no active-halt in full halt", bad, 0);
    check(rdata[7:1] == 7'h00, "R10 write ignored", rdata[7:1], 0);
    wait_flag(b);
    check(b - a == P0 + 30, "R10 count resumes from held value", b - a, P0 + 30);
    rd_csr();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_regs();
    t_prescale();
    t_glitch();
    t_period();
    t_defer();
    t_flag_irq();
    t_ahalt();
    t_fhalt();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

endmodule